// File: doc/BRIEF.md
# Register Access Permission Checker

This block sits between a bus target's request decoder and its register file and decides, cycle by cycle, whether the current register access may proceed. Each request carries a 4-bit role, a read/write flag, a byte address and a size code. The word index taken from the address selects an entry of a static per-register selection vector. That entry names one policy in a packed policy vector, and the role picks one bit out of that policy's read or write bitmap.

An allowed access drives the register file's read or write strobe in the request cycle. A denied, misaligned or out-of-range access never reaches the register file. It still gets a response one cycle later, with zero data and, if the build parameter asks for it, the bus error bit set. In the same cycle the block emits a single-cycle violation pulse that carries the address, role and direction of the offending request, for an error log to capture. No request is ever left without a response.

Top module: `reg_perm_check`

## Requirements
- R1: Policy p occupies bits [32p+31:32p] of `policies_i`. Bits 15:0 are its read bitmap and bits 31:16 its write bitmap. Bit n set grants role n, and bit n clear denies role n.
- R2: The register index is `req_addr_i[ADDR_W-1:2]`. Entry k of the selection vector, bits [SELW*k+SELW-1:SELW*k] of `policy_sel_i`, names the policy that governs register k. A read is checked against that policy's read bitmap and a write against its write bitmap. An entry whose value is NPOL or more denies every access.
- R3: Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. A 2-byte access needs address bit 0 clear. A 4-byte access needs address bits 1:0 clear. An 8-byte access is wider than a register and is always a violation. Any misaligned access is a violation.
- R4: A register index of NREG or more is a violation.
- R5: Every cycle with `req_valid_i` high produces `rsp_valid_o` high exactly one cycle later, whether the access was allowed or denied. No response appears without a request.
- R6: An allowed read returns the `reg_rdata_i` value present in the request cycle. A denied read returns zero, and every write response carries zero data.
- R7: An allowed write raises `reg_we_o` in the request cycle, with `reg_idx_o` equal to the register index. A denied write leaves `reg_we_o` low.
- R8: `rsp_error_o` is high on the response to a violating request when ERR_ON_VIOL is 1. It is always low when ERR_ON_VIOL is 0.
- R9: `viol_o` pulses for one cycle, aligned with the response to a violating request. `viol_addr_o`, `viol_role_o` and `viol_write_o` then hold that request's address, role and write flag.
- R10: `reg_re_o` is high only in the cycle of an allowed read, so a denied read causes no read side effect in the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address within the target |
| req_size_i | input | 2 | Access size code |
| req_role_i | input | 4 | Role of the originator |
| policies_i | input | NPOL*32 | Packed read/write permission bitmaps |
| policy_sel_i | input | NREG*SELW | Policy index for each register |
| reg_idx_o | output | ADDR_W-2 | Register index to the register file |
| reg_we_o | output | 1 | Write strobe, allowed writes only |
| reg_re_o | output | 1 | Read strobe, allowed reads only |
| reg_rdata_i | input | 32 | Read data from the register file |
| rsp_valid_o | output | 1 | Response valid |
| rsp_rdata_o | output | 32 | Response data |
| rsp_error_o | output | 1 | Bus error on violation, when enabled |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_addr_o | output | ADDR_W | Address of the last violating request |
| viol_role_o | output | 4 | Role of the last violating request |
| viol_write_o | output | 1 | Direction of the last violating request |

## Verification
The decision is made combinationally and only the response is registered, so any corrupted decision shows up at the ports at once. A wrong grant appears as a write or read strobe in the request cycle. In the following cycle it appears as non-zero data, a missing error bit or a violation pulse on the response. Bitmap slicing faults and selection-entry faults show up only for particular role and register combinations. The stimulus therefore crosses granted and denied roles on each policy, covers the out-of-range selection entry and register indices, and tries every size code on aligned and unaligned addresses.

// File: rtl/reg_perm_pkg.sv
`timescale 1ns/1ps
package reg_perm_pkg;
   localparam int ROLE_W   = 4;
   localparam int PERM_W   = 1 << ROLE_W;
   localparam int POLICY_W = 2 * PERM_W;
   localparam int DATA_W   = 32;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } acc_size_e;

   // write bitmap in the upper half, read bitmap in the lower half
   typedef struct packed {
      logic [PERM_W-1:0] wr;
      logic [PERM_W-1:0] rd;
   } policy_t;
endpackage

// File: rtl/rpc_align_check.sv
`timescale 1ns/1ps
module rpc_align_check
   import reg_perm_pkg::*;
(
   input  logic [1:0] addr_lo_i,
   input  acc_size_e  size_i,
   output logic       aligned_o
);
   always_comb begin
      unique case (size_i)
         SZ_BYTE: aligned_o = 1'b1;
         SZ_HALF: aligned_o = ~addr_lo_i[0];
         SZ_WORD: aligned_o = (addr_lo_i == 2'b00);
         default: aligned_o = 1'b0;   // wider than a register
      endcase
   end
endmodule

// File: rtl/rpc_policy_select.sv
`timescale 1ns/1ps
module rpc_policy_select
   import reg_perm_pkg::*;
#(
   parameter int NREG  = 16,
   parameter int NPOL  = 4,
   parameter int SELW  = 2,
   parameter int IDX_W = 4
) (
   input  logic [NPOL*POLICY_W-1:0] policies_i,
   input  logic [NREG*SELW-1:0]     policy_sel_i,
   input  logic [IDX_W-1:0]         idx_i,
   input  logic [ROLE_W-1:0]        role_i,
   input  logic                     write_i,
   output logic                     grant_o
);
   policy_t           pol_arr [NPOL];
   logic [SELW-1:0]   sel_arr [NREG];

   for (genvar p = 0; p < NPOL; p++) begin : g_pol
      assign pol_arr[p] = policy_t'(policies_i[p*POLICY_W +: POLICY_W]);
   end
   for (genvar k = 0; k < NREG; k++) begin : g_sel
      assign sel_arr[k] = policy_sel_i[k*SELW +: SELW];
   end

   logic              reg_hit, pol_hit;
   logic [SELW-1:0]   sel;
   policy_t           pol;
   logic [PERM_W-1:0] bitmap;

   always_comb begin
      reg_hit = 1'b0;
      sel     = '0;
      for (int k = 0; k < NREG; k++) begin
         if (idx_i == IDX_W'(k)) begin
            reg_hit = 1'b1;
            sel     = sel_arr[k];
         end
      end
      pol_hit = 1'b0;
      pol     = '0;
      for (int p = 0; p < NPOL; p++) begin
         if (sel == SELW'(p)) begin
            pol_hit = 1'b1;
            pol     = pol_arr[p];
         end
      end
      bitmap  = write_i ? pol.wr : pol.rd;
      grant_o = reg_hit & pol_hit & bitmap[role_i];
   end
endmodule

// File: rtl/reg_perm_check.sv
`timescale 1ns/1ps
module reg_perm_check
   import reg_perm_pkg::*;
#(
   parameter int NREG        = 16,
   parameter int NPOL        = 4,
   parameter int SELW        = 2,
   parameter int ADDR_W      = 6,
   parameter bit ERR_ON_VIOL = 1'b1,
   localparam int IDX_W      = ADDR_W - 2
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     req_valid_i,
   input  logic                     req_write_i,
   input  logic [ADDR_W-1:0]        req_addr_i,
   input  logic [1:0]               req_size_i,
   input  logic [ROLE_W-1:0]        req_role_i,
   input  logic [NPOL*POLICY_W-1:0] policies_i,
   input  logic [NREG*SELW-1:0]     policy_sel_i,
   output logic [IDX_W-1:0]         reg_idx_o,
   output logic                     reg_we_o,
   output logic                     reg_re_o,
   input  logic [DATA_W-1:0]        reg_rdata_i,
   output logic                     rsp_valid_o,
   output logic [DATA_W-1:0]        rsp_rdata_o,
   output logic                     rsp_error_o,
   output logic                     viol_o,
   output logic [ADDR_W-1:0]        viol_addr_o,
   output logic [ROLE_W-1:0]        viol_role_o,
   output logic                     viol_write_o
);
   // elaboration-time parameter checks
   if (ADDR_W < 3) begin : g_chk_addr
      $error("ADDR_W must leave at least one index bit");
   end
   if (NREG < 1 || NREG > (1 << IDX_W)) begin : g_chk_nreg
      $error("NREG must be between 1 and 2**(ADDR_W-2)");
   end
   if (NPOL < 1 || NPOL > (1 << SELW)) begin : g_chk_npol
      $error("NPOL must be between 1 and 2**SELW");
   end

   logic aligned, grant, allow, viol, err_d;

   assign reg_idx_o = req_addr_i[ADDR_W-1:2];

   rpc_align_check u_align (
      .addr_lo_i (req_addr_i[1:0]),
      .size_i    (acc_size_e'(req_size_i)),
      .aligned_o (aligned)
   );

   rpc_policy_select #(
      .NREG  (NREG),
      .NPOL  (NPOL),
      .SELW  (SELW),
      .IDX_W (IDX_W)
   ) u_select (
      .policies_i   (policies_i),
      .policy_sel_i (policy_sel_i),
      .idx_i        (reg_idx_o),
      .role_i       (req_role_i),
      .write_i      (req_write_i),
      .grant_o      (grant)
   );

   assign allow    = aligned & grant;
   assign viol     = req_valid_i & ~allow;
   assign reg_we_o = req_valid_i & req_write_i & allow;
   assign reg_re_o = req_valid_i & ~req_write_i & allow;

   if (ERR_ON_VIOL) begin : g_err_on
      assign err_d = viol;
   end else begin : g_err_off
      assign err_d = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsp_valid_o  <= 1'b0;
         rsp_rdata_o  <= '0;
         rsp_error_o  <= 1'b0;
         viol_o       <= 1'b0;
         viol_addr_o  <= '0;
         viol_role_o  <= '0;
         viol_write_o <= 1'b0;
      end else begin
         rsp_valid_o <= req_valid_i;
         rsp_rdata_o <= reg_re_o ? reg_rdata_i : '0;
         rsp_error_o <= err_d;
         viol_o      <= viol;
         if (viol) begin
            viol_addr_o  <= req_addr_i;
            viol_role_o  <= req_role_i;
            viol_write_o <= req_write_i;
         end
      end
   end
endmodule

// File: rtl/reg_perm_check_chk.sv
`timescale 1ns/1ps
module reg_perm_check_chk #(
   parameter bit ERR_ON_VIOL = 1'b1
) (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        req_valid_i,
   input logic        req_write_i,
   input logic [1:0]  req_size_i,
   input logic        reg_we_o,
   input logic        reg_re_o,
   input logic        rsp_valid_o,
   input logic [31:0] rsp_rdata_o,
   input logic        rsp_error_o,
   input logic        viol_o,
   input logic        viol_write_o
);
   AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i |=> rsp_valid_o);  // R5
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i |=> !rsp_valid_o);  // R5
   AST_DENY_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (viol_o && !viol_write_o) |-> (rsp_rdata_o == 32'd0));  // R6
   AST_WE_ONLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_we_o |-> (req_valid_i && req_write_i && req_size_i != 2'd3));  // R7
   AST_WE_NO_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_we_o |=> !viol_o);  // R7
   AST_RE_NO_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_re_o |=> !viol_o);  // R10
   AST_ERR_BY_PARAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o |-> (rsp_error_o == (ERR_ON_VIOL && viol_o)));  // R8
   AST_VIOL_WITH_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      viol_o |-> rsp_valid_o);  // R9
endmodule

bind reg_perm_check reg_perm_check_chk #(.ERR_ON_VIOL(ERR_ON_VIOL)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .req_valid_i  (req_valid_i),
   .req_write_i  (req_write_i),
   .req_size_i   (req_size_i),
   .reg_we_o     (reg_we_o),
   .reg_re_o     (reg_re_o),
   .rsp_valid_o  (rsp_valid_o),
   .rsp_rdata_o  (rsp_rdata_o),
   .rsp_error_o  (rsp_error_o),
   .viol_o       (viol_o),
   .viol_write_o (viol_write_o)
);

// File: tb/reg_perm_check_bench.sv
`timescale 1ns/1ps
module reg_perm_check_bench;
   localparam int NREG = 6;
   localparam int NPOL = 3;
   localparam int SELW = 2;
   localparam int AW   = 5;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic              rst_ni;
   logic              req_valid, req_write;
   logic [AW-1:0]     req_addr;
   logic [1:0]        req_size;
   logic [3:0]        req_role;
   logic [NPOL*32-1:0] policies;
   logic [NREG*SELW-1:0] psel;
   logic [AW-3:0]     reg_idx, reg_idx_n;
   logic              reg_we, reg_re, reg_we_n, reg_re_n;
   logic [31:0]       reg_rdata;
   logic              rsp_valid, rsp_error, viol, viol_write;
   logic [31:0]       rsp_rdata;
   logic [AW-1:0]     viol_addr;
   logic [3:0]        viol_role;
   logic              rsp_valid_n, rsp_error_n, viol_n, viol_write_n;
   logic [31:0]       rsp_rdata_n;
   logic [AW-1:0]     viol_addr_n;
   logic [3:0]        viol_role_n;

   // register file model: each register reads as A000_00xx with its index
   assign reg_rdata = 32'hA000_0000 | 32'(reg_idx);

   reg_perm_check #(.NREG(NREG), .NPOL(NPOL), .SELW(SELW), .ADDR_W(AW), .ERR_ON_VIOL(1'b1))
   u_reg_perm_check (
      .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_write_i(req_write),
      .req_addr_i(req_addr), .req_size_i(req_size), .req_role_i(req_role),
      .policies_i(policies), .policy_sel_i(psel), .reg_idx_o(reg_idx),
      .reg_we_o(reg_we), .reg_re_o(reg_re), .reg_rdata_i(reg_rdata),
      .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_error_o(rsp_error),
      .viol_o(viol), .viol_addr_o(viol_addr), .viol_role_o(viol_role),
      .viol_write_o(viol_write));

   reg_perm_check #(.NREG(NREG), .NPOL(NPOL), .SELW(SELW), .ADDR_W(AW), .ERR_ON_VIOL(1'b0))
   u_noerr (
      .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_write_i(req_write),
      .req_addr_i(req_addr), .req_size_i(req_size), .req_role_i(req_role),
      .policies_i(policies), .policy_sel_i(psel), .reg_idx_o(reg_idx_n),
      .reg_we_o(reg_we_n), .reg_re_o(reg_re_n), .reg_rdata_i(reg_rdata),
      .rsp_valid_o(rsp_valid_n), .rsp_rdata_o(rsp_rdata_n), .rsp_error_o(rsp_error_n),
      .viol_o(viol_n), .viol_addr_o(viol_addr_n), .viol_role_o(viol_role_n),
      .viol_write_o(viol_write_n));

   // policy table used by the bench (R1, R2)
   logic [15:0] rd_map [NPOL] = '{16'h0001, 16'hFFFF, 16'h8004};
   logic [15:0] wr_map [NPOL] = '{16'h0001, 16'h0005, 16'h0000};
   int          sel_map [NREG] = '{0, 1, 2, 1, 3, 0};

   typedef struct {
      logic        viol;
      logic [31:0] rdata;
      logic [AW-1:0] addr;
      logic [3:0]  role;
      logic        wr;
   } exp_t;
   exp_t sb_q [$];

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit model_allow(input logic wr, input logic [AW-1:0] addr,
                                      input logic [1:0] size, input logic [3:0] role);
      bit al;
      int idx, s;
      logic [15:0] perm;
      case (size)
         2'd0: al = 1'b1;
         2'd1: al = (addr[0] == 1'b0);
         2'd2: al = (addr[1:0] == 2'b00);
         default: al = 1'b0;
      endcase
      idx = int'(addr[AW-1:2]);
      if (idx >= NREG) return 1'b0;        // R4
      s = sel_map[idx];
      if (s >= NPOL) return 1'b0;          // R2 out-of-range entry
      perm = wr ? wr_map[s] : rd_map[s];
      return al && perm[role];
   endfunction

   task automatic send(input logic wr, input logic [AW-1:0] addr, input logic [1:0] size,
                       input logic [3:0] role);
      bit ok;
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = size; req_role = role;
      #1;
      ok = model_allow(wr, addr, size, role);
      check(reg_we == (ok && wr), "R7 write strobe", 32'(reg_we), 32'(ok && wr));
      check(reg_re == (ok && !wr), "R10 read strobe", 32'(reg_re), 32'(ok && !wr));
      if (ok) check(reg_idx == addr[AW-1:2], "R7 register index", 32'(reg_idx), 32'(addr[AW-1:2]));
      e.viol  = !ok;
      e.rdata = (ok && !wr) ? (32'hA000_0000 | 32'(addr[AW-1:2])) : 32'd0;
      e.addr  = addr; e.role = role; e.wr = wr;
      sb_q.push_back(e);
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   // monitor: compares each response against the oldest expected item
   always @(negedge clk) begin
      if (rst_ni && !done) begin
         if (rsp_valid) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "R5 response without request", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               check(rsp_rdata == e.rdata, "R6 response data", rsp_rdata, e.rdata);
               check(rsp_error == e.viol, "R8 error bit", 32'(rsp_error), 32'(e.viol));
               check(viol == e.viol, "R9 violation pulse", 32'(viol), 32'(e.viol));
               check(rsp_valid_n && !rsp_error_n, "R8 error disabled variant",
                     {30'd0, rsp_valid_n, rsp_error_n}, 32'd2);
               if (e.viol) begin
                  check(viol_addr == e.addr, "R9 logged address", 32'(viol_addr), 32'(e.addr));
                  check(viol_role == e.role, "R9 logged role", 32'(viol_role), 32'(e.role));
                  check(viol_write == e.wr, "R9 logged direction", 32'(viol_write), 32'(e.wr));
               end
            end
         end else begin
            check(sb_q.size() == 0, "R5 missing response", 32'(sb_q.size()), 32'd0);
            check(!viol, "R9 pulse without response", 32'(viol), 32'd0);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int p = 0; p < NPOL; p++) policies[p*32 +: 32] = {wr_map[p], rd_map[p]};
      for (int k = 0; k < NREG; k++) psel[k*SELW +: SELW] = SELW'(sel_map[k]);
      rst_ni = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_addr = '0; req_size = 2'd2; req_role = '0;
      repeat (3) @(negedge clk);
      check(!rsp_valid && !viol && !rsp_error && rsp_rdata == 0, "R5 reset state",
            {29'd0, rsp_valid, viol, rsp_error}, 32'd0);
      rst_ni = 1'b1;
      idle(2);
      // R1/R6: granted read, role 5 on all-read policy
      send(1'b0, 5'h04, 2'd2, 4'd5);
      // R7: write denied for role 5, granted for role 2
      send(1'b1, 5'h04, 2'd2, 4'd5);
      send(1'b1, 5'h04, 2'd2, 4'd2);
      idle(1);
      // R1: role 1 denied on role-0-only policy
      send(1'b0, 5'h00, 2'd2, 4'd1);
      // R3: size / alignment cases on register 0, role 0
      send(1'b0, 5'h02, 2'd1, 4'd0);
      send(1'b0, 5'h01, 2'd1, 4'd0);
      send(1'b0, 5'h02, 2'd2, 4'd0);
      send(1'b0, 5'h03, 2'd0, 4'd0);
      send(1'b0, 5'h00, 2'd3, 4'd0);
      send(1'b1, 5'h00, 2'd3, 4'd0);
      idle(2);
      // R1: bit 15 and bit 2 granted, bit 3 denied on policy 2
      send(1'b0, 5'h08, 2'd2, 4'd15);
      send(1'b0, 5'h08, 2'd2, 4'd2);
      send(1'b0, 5'h08, 2'd2, 4'd3);
      send(1'b1, 5'h08, 2'd2, 4'd2);
      // R2: register 3 shares policy 1; register 4 selects missing policy 3
      send(1'b0, 5'h0C, 2'd2, 4'd9);
      send(1'b0, 5'h10, 2'd2, 4'd0);
      send(1'b1, 5'h10, 2'd2, 4'd0);
      // R4: register indices 6 and 7 do not exist
      send(1'b0, 5'h18, 2'd2, 4'd0);
      send(1'b1, 5'h1C, 2'd2, 4'd0);
      // R7: allowed write to register 5
      send(1'b1, 5'h14, 2'd2, 4'd0);
      send(1'b0, 5'h16, 2'd1, 4'd0);
      idle(3);
      check(sb_q.size() == 0, "R5 all responses returned", 32'(sb_q.size()), 32'd0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule